// File: doc/BRIEF.md
# SPI Bit-Clock Prescaler

This block turns the core clock into the timing of an SPI bit clock. It reads a packed 8-bit prescale field from the interface configuration, together with a mode select. It drives a square bit clock, a one-cycle strobe at the middle of each bit period, and a one-cycle strobe at the end of each bit period. The shift engine uses the two strobes to launch and capture data. It does not need to look at the clock level.

There are two encodings. In the extended mode, a 4-bit linear factor is multiplied by a power of two whose 3-bit exponent is split across the byte. The ratio is built from a linear counter followed by a power-of-two counter. In the legacy mode, a 5-bit code selects even ratios from 4 to 30. A new setting is only taken while the bus is idle. When it is taken, both counters and the clock level start again from zero, so the first bit after a change has a full, clean period.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: With `ext_mode_i`=1, the bit period is S×2^P core cycles. S is `presc_i[3:0]`. P is a 3-bit exponent whose bit 0 is `presc_i[4]` and whose bits 2:1 are `presc_i[7:6]`. The largest ratio is 15×128 = 1920.
- R2: In the extended mode, `presc_i[5]` has no effect on the ratio.
- R3: In the extended mode, S=0 acts as S=1. A resulting ratio of 1 (S≤1 with P=0) is raised to 2.
- R4: With `ext_mode_i`=0, only `presc_i[4:0]` is used. A code of 0x10+N with N from 2 to 15 gives a period of 2N cycles. Bits 7:5 are ignored.
- R5: In the legacy mode, any code below 0x12 gives a period of 4 cycles.
- R6: Counting from the first cycle after a restart, `half_stb_o` is high for one cycle in cycle floor(R/2)−1 of each period. `edge_stb_o` is high for one cycle in cycle R−1 of each period. The two strobes are never high together.
- R7: `sclk_o` is low for the first floor(R/2) cycles of each period and high for the rest. It changes only in the cycle after a strobe or a restart.
- R8: While `idle_i` is low, changes to `ext_mode_i` or `presc_i` are ignored and the running period is kept.
- R9: A setting that differs from the active one and is seen while `idle_i` is high is taken at that clock edge. From the next cycle, the counters restart at zero and `sclk_o` is low. No strobe is given in the taking cycle.
- R10: Reset drives `sclk_o` and both strobes low. The active setting becomes legacy code 0, so the period is 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | 1 = extended linear×power-of-two encoding, 0 = legacy even encoding |
| presc_i | input | 8 | Packed prescale field |
| idle_i | input | 1 | High when no transfer is in progress; a new setting may be taken |
| sclk_o | output | 1 | Square bit clock, low in the first half of each period |
| half_stb_o | output | 1 | One-cycle strobe at the end of the first half-period |
| edge_stb_o | output | 1 | One-cycle strobe at the end of the full period |

## Verification
A table of settings covers several kinds of case. Odd and even ratios with no exponent separate the split half-period from the exact one. Settings that differ only in the exponent bits 4, 6 and 7 confirm that each of those bits is decoded at its own position. Setting bit 5, or the legacy upper bits, shows that they are ignored. The zero, one and below-minimum codes exercise each clamp. The 1920 ratio exercises the widest cascade. For each setting, the bench measures the offsets of the first half strobe, the first edge strobe and the second edge strobe from the restart, plus the clock level at two points. A changed setting applied while the bus is busy must leave the old period spacing in place until the bus goes idle.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int unsigned SPR_W   = 4;
  localparam int unsigned SPPR_W  = 3;
  localparam int unsigned PRESC_W = 8;

  typedef struct packed {
    logic [SPR_W-1:0]  lin;
    logic [SPPR_W-1:0] exp2;
  } div_cfg_t;
endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
  import spi_presc_pkg::*;
(
  input  logic               ext_mode_i,
  input  logic [PRESC_W-1:0] presc_i,
  output div_cfg_t           cfg_o
);
  localparam logic [4:0] LEG_MIN = 5'h12;

  logic [SPR_W-1:0]  ext_lin;
  logic [SPPR_W-1:0] ext_exp;
  logic [4:0]        leg_code;
  logic              unused_gap;

  assign unused_gap = presc_i[5];
  assign ext_exp    = {presc_i[7:6], presc_i[4]};
  assign leg_code   = presc_i[4:0];

  always_comb begin
    ext_lin = presc_i[SPR_W-1:0];
    if (ext_lin == '0)
      ext_lin = SPR_W'(1);
    if ((ext_exp == '0) && (ext_lin == SPR_W'(1)))
      ext_lin = SPR_W'(2);
  end

  always_comb begin
    if (ext_mode_i) begin
      cfg_o.lin  = ext_lin;
      cfg_o.exp2 = ext_exp;
    end else begin
      cfg_o.exp2 = SPPR_W'(1);
      if (leg_code < LEG_MIN)
        cfg_o.lin = SPR_W'(2);
      else
        cfg_o.lin = leg_code[SPR_W-1:0];
    end
  end
endmodule

// File: rtl/spi_presc_lin.sv
module spi_presc_lin #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o,
  output logic         mid_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] last_val;
  logic [W-1:0] mid_val;

  assign last_val = lim_i - W'(1);
  assign mid_val  = (lim_i >> 1) - W'(1);
  assign wrap_o   = (cnt_q == last_val);
  assign mid_o    = (cnt_q == mid_val);

  always_comb begin
    if (clr_i || wrap_o)
      cnt_d = '0;
    else
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_presc_pow.sv
module spi_presc_pow #(
  parameter int unsigned EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [EW-1:0] exp_i,
  output logic          half_o,
  output logic          full_o
);
  localparam int unsigned CW = (1 << EW) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   span;
  logic [CW-1:0] full_val;
  logic [CW-1:0] half_val;

  assign span     = {{CW{1'b0}}, 1'b1} << exp_i;
  assign full_val = CW'(span - (CW+1)'(1));
  assign half_val = CW'((span >> 1) - (CW+1)'(1));
  assign full_o   = step_i && (cnt_q == full_val);
  assign half_o   = step_i && (exp_i != '0) && (cnt_q == half_val);

  always_comb begin
    if (clr_i || full_o)
      cnt_d = '0;
    else if (step_i)
      cnt_d = cnt_q + CW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_presc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_mode_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               idle_i,
  output logic               sclk_o,
  output logic               half_stb_o,
  output logic               edge_stb_o
);
  logic               act_mode_q;
  logic [PRESC_W-1:0] act_presc_q;
  logic               act_mode_d;
  logic [PRESC_W-1:0] act_presc_d;
  logic               take;
  div_cfg_t           cfg;
  logic               lin_wrap;
  logic               lin_mid;
  logic               pow_half;
  logic               pow_full;
  logic               half_raw;
  logic               sclk_q;
  logic               sclk_d;

  assign take = idle_i && ({ext_mode_i, presc_i} != {act_mode_q, act_presc_q});

  always_comb begin
    act_mode_d  = act_mode_q;
    act_presc_d = act_presc_q;
    if (take) begin
      act_mode_d  = ext_mode_i;
      act_presc_d = presc_i;
    end
  end

  spi_presc_decode u_dec (
    .ext_mode_i (act_mode_q),
    .presc_i    (act_presc_q),
    .cfg_o      (cfg)
  );

  spi_presc_lin #(.W(SPR_W)) u_lin (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (take),
    .lim_i  (cfg.lin),
    .wrap_o (lin_wrap),
    .mid_o  (lin_mid)
  );

  spi_presc_pow #(.EW(SPPR_W)) u_pow (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (take),
    .step_i (lin_wrap),
    .exp_i  (cfg.exp2),
    .half_o (pow_half),
    .full_o (pow_full)
  );

  assign half_raw   = (cfg.exp2 == '0) ? lin_mid : pow_half;
  assign half_stb_o = half_raw && !take;
  assign edge_stb_o = pow_full && !take;
  assign sclk_o     = sclk_q;

  always_comb begin
    if (take)
      sclk_d = 1'b0;
    else if (half_stb_o)
      sclk_d = 1'b1;
    else if (edge_stb_o)
      sclk_d = 1'b0;
    else
      sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q  <= 1'b0;
      act_presc_q <= '0;
      sclk_q      <= 1'b0;
    end else begin
      act_mode_q  <= act_mode_d;
      act_presc_q <= act_presc_d;
      sclk_q      <= sclk_d;
    end
  end
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle_i,
  input logic       sclk_o,
  input logic       half_stb_o,
  input logic       edge_stb_o,
  input logic [8:0] act_cfg
);
  // R6: the two strobes never coincide
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_stb_o && edge_stb_o));

  // R7: the half strobe falls in the low half, the edge strobe in the high half
  a_r7_half_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb_o |-> !sclk_o);

  a_r7_edge_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb_o |-> sclk_o);

  // R7: the clock rises only after a half strobe
  a_r7_rise_after_half: assert property (@(posedge clk) disable iff (!rst_n)
    !half_stb_o |=> !$rose(sclk_o));

  a_r7_half_raises: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb_o |=> sclk_o);

  // R8: the active setting holds while the bus is busy
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(act_cfg));
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .idle_i     (idle_i),
  .sclk_o     (sclk_o),
  .half_stb_o (half_stb_o),
  .edge_stb_o (edge_stb_o),
  .act_cfg    ({act_mode_q, act_presc_q})
);

// File: tb/spi_sclk_prescaler_tb.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_tb_top;
  logic       clk;
  logic       rst_n;
  logic       ext_mode;
  logic [7:0] presc;
  logic       idle;
  logic       sclk;
  logic       half_stb;
  logic       edge_stb;

  int checks;
  int fails;
  bit done;

  spi_sclk_prescaler dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode_i (ext_mode),
    .presc_i    (presc),
    .idle_i     (idle),
    .sclk_o     (sclk),
    .half_stb_o (half_stb),
    .edge_stb_o (edge_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {mode, presc, period R, first half H}
  localparam int NV = 17;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 8'h03, 11'd3,    11'd1},
    {1'b1, 8'h00, 11'd2,    11'd1},
    {1'b1, 8'h01, 11'd2,    11'd1},
    {1'b1, 8'h05, 11'd5,    11'd2},
    {1'b1, 8'h13, 11'd6,    11'd3},
    {1'b1, 8'h33, 11'd6,    11'd3},
    {1'b1, 8'h42, 11'd8,    11'd4},
    {1'b1, 8'hD0, 11'd128,  11'd64},
    {1'b1, 8'hDF, 11'd1920, 11'd960},
    {1'b1, 8'h8F, 11'd240,  11'd120},
    {1'b1, 8'h0F, 11'd15,   11'd7},
    {1'b0, 8'h1F, 11'd30,   11'd15},
    {1'b0, 8'h12, 11'd4,    11'd2},
    {1'b0, 8'h11, 11'd4,    11'd2},
    {1'b0, 8'h05, 11'd4,    11'd2},
    {1'b0, 8'h17, 11'd14,   11'd7},
    {1'b0, 8'hF7, 11'd14,   11'd7}
  };

  function automatic string vtag(int i);
    case (i)
      1, 2, 7:   return "R3";
      5:         return "R2";
      11, 12:    return "R4";
      13, 14:    return "R5";
      15, 16:    return "R4";
      default:   return "R1";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(logic m, logic [7:0] p, int r, int h, string tg);
    int fh;
    int fe;
    int se;
    fh = -1; fe = -1; se = -1;
    @(negedge clk);
    ext_mode = m; presc = p; idle = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= 2*r + 1; c++) begin
      @(negedge clk);
      if (c == 0) chk(sclk == 1'b0, {tg, " R9 sclk low after restart"}, sclk, 0);
      if (c == h) chk(sclk == 1'b1, {tg, " R7 sclk high in second half"}, sclk, 1);
      if (c == r) chk(sclk == 1'b0, {tg, " R7 sclk low in next period"}, sclk, 0);
      if (half_stb && fh < 0) fh = c;
      if (edge_stb) begin
        if (fe < 0) fe = c;
        else if (se < 0) se = c;
      end
    end
    chk(fh == h - 1,     {tg, " R6 first half strobe"}, fh, h - 1);
    chk(fe == r - 1,     {tg, " R9 first edge strobe"}, fe, r - 1);
    chk(se == 2*r - 1,   {tg, " R6 second edge strobe"}, se, 2*r - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int fh;
    int fe;
    int se;
    int e1;
    int e2;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; ext_mode = 1'b0; presc = 8'h00; idle = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sclk == 1'b0,     "R10 sclk in reset", sclk, 0);
    chk(half_stb == 1'b0, "R10 half strobe in reset", half_stb, 0);
    chk(edge_stb == 1'b0, "R10 edge strobe in reset", edge_stb, 0);
    rst_n = 1'b1;
    fh = -1; fe = -1; se = -1;
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      if (half_stb && fh < 0) fh = c;
      if (edge_stb) begin
        if (fe < 0) fe = c;
        else if (se < 0) se = c;
      end
    end
    chk(fh == 1, "R10 reset ratio half strobe", fh, 1);
    chk(fe == 3, "R10 reset ratio edge strobe", fe, 3);
    chk(se == 7, "R10 reset ratio second edge", se, 7);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][30], VEC[i][29:22], int'(VEC[i][21:11]), int'(VEC[i][10:0]), vtag(i));

    // R8: a change while busy keeps the old period (ratio 6)
    run_vec(1'b1, 8'h13, 6, 3, "R1");
    @(negedge clk);
    idle = 1'b0; presc = 8'hDF;
    e1 = -1; e2 = -1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (edge_stb) begin
        if (e1 < 0) e1 = c;
        else if (e2 < 0) e2 = c;
      end
    end
    chk(e1 >= 0, "R8 edge strobes continue while busy", e1, 0);
    chk((e2 - e1) == 6, "R8 period kept while busy", e2 - e1, 6);
    run_vec(1'b1, 8'h05, 5, 2, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule